// File: doc/BRIEF.md
# Sector Erase Accumulation Controller

This block is the erase-sequencing core of a behavioural flash controller. It takes command events that an upstream decoder has already recognised, each carrying a sector index. A sector erase command opens a quiet-time window. While the window is open, further "add sector" cycles mark more sectors in a bitmap. Each added sector pushes the end of the window out by a full window length. When a whole window passes with no new sector, the erase starts. It runs for a fixed number of cycles per marked sector. A host can pause it with a suspend event and continue it with a resume event.

A chip erase skips the window and marks every sector at once. Progress is reported in a status byte with three live bits:

- bit 7 is the completion poll bit.
- bit 6 is the toggle bit.
- bit 3 is the erase-timer bit. It is 0 while the window accepts sectors and 1 once erasing has begun.

The command input is a valid/ready channel. `cmd_ready` is held high at all times, so the block never applies back-pressure. A command that does not apply in the current phase is consumed and dropped. The status read strobe and all outputs are plain signals.

Top module: `sec_erase_ctl`

## Requirements
- R1: After reset the controller is in read mode: `status` is 8'h80, `sector_map` is all zeros, `erase_busy` is 0, and `cmd_ready` is 1 at all times.
- R2: In read mode, a sector erase command (`cmd_op` = 1) sets `erase_busy` on the next cycle, sets `sector_map` to the one-hot of `cmd_sector`, and holds status bit 3 at 0 for WINDOW_CYCLES cycles. Bit 3 then becomes 1.
- R3: While bit 3 is 0, an add-sector cycle (`cmd_op` = 2) ORs its sector into `sector_map` and restarts the window, so bit 3 stays 0 for WINDOW_CYCLES further cycles. This also applies to a cycle in the last window cycle and to a sector that is already marked.
- R4: Erasing (bit 3 = 1, not suspended) lasts CYCLES_PER_SECTOR times the number of marked sectors. After that, `sector_map` clears, bit 3 returns to 0, bit 7 returns to 1 and `erase_busy` falls.
- R5: While bit 3 is 1, add-sector, sector erase, chip erase and resume commands are ignored. They change neither `sector_map` nor the erase length.
- R6: In read mode, a chip erase (`cmd_op` = 3) sets bit 3 and an all-ones `sector_map` on the next cycle, with no window. It erases for N_SECT × CYCLES_PER_SECTOR cycles.
- R7: A suspend (`cmd_op` = 4) during erasing freezes the remaining count, and bits 3 and 7 hold their values. A resume (`cmd_op` = 5) continues the count. Suspend and resume in read mode or during the window have no effect.
- R8: Bit 7 is 0 whenever `erase_busy` is 1. Bit 6 inverts once per cycle in which `stat_rd` is high while busy, and holds when idle. Bits 5, 4, 2, 1 and 0 are always 0.
- R9: In read mode, the no-op (`cmd_op` = 0), add-sector, suspend and resume commands are ignored, and the controller stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command event present |
| cmd_ready | output | 1 | Always 1; commands are never stalled |
| cmd_op | input | 3 | Command code (0 none, 1 sector erase, 2 add sector, 3 chip erase, 4 suspend, 5 resume) |
| cmd_sector | input | SECT_W | Sector index of the command |
| stat_rd | input | 1 | Status read strobe (drives the toggle bit) |
| status | output | 8 | Status byte: bit 7 done poll, bit 6 toggle, bit 3 erase started |
| sector_map | output | N_SECT | Bitmap of sectors selected for erase |
| erase_busy | output | 1 | Controller is out of read mode |

## Verification
The bench builds the block with 8 sectors, a 5-cycle window and 3 cycles per sector. With 8 sectors, all 255 non-empty sector sets can be reached by accumulation. The gap before each added sector is varied across every window position, including the last open cycle. With these settings a chip erase takes only 24 cycles. A suspend can therefore be placed at a known point and the remaining count predicted exactly.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_SECT_ERASE = 3'd1,
    OP_SECT_ADD   = 3'd2,
    OP_CHIP_ERASE = 3'd3,
    OP_SUSPEND    = 3'd4,
    OP_RESUME     = 3'd5
  } erase_op_e;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2,
    ST_HOLD   = 2'd3
  } ctl_state_e;

  localparam int STAT_DONE_BIT   = 7;
  localparam int STAT_TOGGLE_BIT = 6;
  localparam int STAT_TIMER_BIT  = 3;
endpackage

// File: rtl/sec_quiet_timer.sv
module sec_quiet_timer #(
  parameter int WINDOW_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int TW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  // Counts quiet cycles while the window is open; held at zero otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + TW'(1);
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/sec_map_accum.sv
module sec_map_accum #(
  parameter int N_SECT = 16,
  localparam int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int CNT_W  = $clog2(N_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set_one,
  input  logic              set_all,
  input  logic [SECT_W-1:0] idx,
  output logic [N_SECT-1:0] map,
  output logic [CNT_W-1:0]  count
);
  logic [N_SECT-1:0] map_q;
  logic [N_SECT-1:0] map_d;

  for (genvar i = 0; i < N_SECT; i++) begin : g_bit
    assign map_d[i] = clr ? 1'b0
                    : (map_q[i] | set_all | (set_one && (idx == SECT_W'(i))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N_SECT; i++) count = count + CNT_W'(map_q[i]);
  end

  assign map = map_q;
endmodule

// File: rtl/sec_erase_count.sv
module sec_erase_count #(
  parameter int N_SECT            = 16,
  parameter int CYCLES_PER_SECTOR = 4,
  localparam int CNT_W = $clog2(N_SECT + 1),
  localparam int TOTAL = N_SECT * CYCLES_PER_SECTOR,
  localparam int RW    = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_all,
  input  logic [CNT_W-1:0] sel_count,
  input  logic             run,
  output logic             last
);
  logic [RW-1:0] remain_q;
  logic [RW-1:0] load_val;

  assign load_val = load_all ? RW'(TOTAL)
                             : RW'(sel_count) * RW'(CYCLES_PER_SECTOR);

  // Remaining erase cycles; frozen whenever run is low (suspend).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (run && remain_q != '0) remain_q <= remain_q - RW'(1);
  end

  assign last = (remain_q == RW'(1));
endmodule

// File: rtl/sec_status_byte.sv
module sec_status_byte
  import sec_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       started,
  input  logic       rd,
  output logic [7:0] status
);
  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tgl_q <= 1'b0;
    else if (rd && busy) tgl_q <= ~tgl_q;
  end

  always_comb begin
    status                  = '0;
    status[STAT_DONE_BIT]   = ~busy;
    status[STAT_TOGGLE_BIT] = tgl_q;
    status[STAT_TIMER_BIT]  = started;
  end
endmodule

// File: rtl/sec_erase_ctl.sv
module sec_erase_ctl
  import sec_erase_pkg::*;
#(
  parameter int N_SECT            = 16,
  parameter int WINDOW_CYCLES     = 8,
  parameter int CYCLES_PER_SECTOR = 4,
  localparam int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1,
  localparam int CNT_W  = $clog2(N_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              stat_rd,
  output logic [7:0]        status,
  output logic [N_SECT-1:0] sector_map,
  output logic              erase_busy
);
  ctl_state_e state_q, state_d;
  erase_op_e  op;
  logic       win_run, win_expired, win_restart;
  logic       map_clr, map_set_one, map_set_all;
  logic [CNT_W-1:0] map_count;
  logic       cnt_load, cnt_load_all, cnt_run, cnt_last;

  assign cmd_ready = 1'b1;
  assign op        = erase_op_e'(cmd_op);
  assign win_run   = (state_q == ST_WINDOW);

  always_comb begin
    state_d      = state_q;
    win_restart  = 1'b0;
    map_clr      = 1'b0;
    map_set_one  = 1'b0;
    map_set_all  = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_all = 1'b0;
    cnt_run      = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (cmd_valid && op == OP_SECT_ERASE) begin
          state_d     = ST_WINDOW;
          map_set_one = 1'b1;
        end else if (cmd_valid && op == OP_CHIP_ERASE) begin
          state_d      = ST_ERASE;
          map_set_all  = 1'b1;
          cnt_load     = 1'b1;
          cnt_load_all = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (cmd_valid && op == OP_SECT_ADD) begin
          map_set_one = 1'b1;
          win_restart = 1'b1;
        end else if (win_expired) begin
          state_d  = ST_ERASE;
          cnt_load = 1'b1;
        end
      end
      ST_ERASE: begin
        if (cmd_valid && op == OP_SUSPEND) begin
          state_d = ST_HOLD;
        end else begin
          cnt_run = 1'b1;
          if (cnt_last) begin
            state_d = ST_READ;
            map_clr = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cmd_valid && op == OP_RESUME) state_d = ST_ERASE;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READ;
    else        state_q <= state_d;
  end

  sec_quiet_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (win_run),
    .restart (win_restart),
    .expired (win_expired)
  );

  sec_map_accum #(.N_SECT(N_SECT)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (map_clr),
    .set_one (map_set_one),
    .set_all (map_set_all),
    .idx     (cmd_sector),
    .map     (sector_map),
    .count   (map_count)
  );

  sec_erase_count #(
    .N_SECT            (N_SECT),
    .CYCLES_PER_SECTOR (CYCLES_PER_SECTOR)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_load),
    .load_all  (cnt_load_all),
    .sel_count (map_count),
    .run       (cnt_run),
    .last      (cnt_last)
  );

  assign erase_busy = (state_q != ST_READ);

  sec_status_byte u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (erase_busy),
    .started ((state_q == ST_ERASE) || (state_q == ST_HOLD)),
    .rd      (stat_rd),
    .status  (status)
  );
endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk #(
  parameter int N_SECT = 16,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [SECT_W-1:0] cmd_sector,
  input logic              stat_rd,
  input logic [7:0]        status,
  input logic [N_SECT-1:0] sector_map,
  input logic              erase_busy
);
  // R2: a sector erase from read mode opens the window with a one-hot map
  p_window_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && !erase_busy) |=>
      (erase_busy && !status[3] && sector_map == (N_SECT'(1) << $past(cmd_sector))));

  // R4: leaving busy always leaves an empty map and a cleared timer bit
  p_finish_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (sector_map == '0 && !status[3]));

  // R5: once erasing has begun the map only changes by being cleared at the end
  p_map_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && erase_busy) |=> (status[3] ? $stable(sector_map) : (sector_map == '0)));

  // R6: chip erase marks every sector and starts at once
  p_chip_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && !erase_busy) |=> (&sector_map && status[3]));

  // R8: each status read while busy inverts the toggle bit
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && stat_rd) |=> (status[6] != $past(status[6])));
endmodule

bind sec_erase_ctl sec_erase_chk #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_sector (cmd_sector),
  .stat_rd    (stat_rd),
  .status     (status),
  .sector_map (sector_map),
  .erase_busy (erase_busy)
);

// File: tb/tb_sec_erase_ctl.sv
module tb_sec_erase_ctl;
  localparam int N   = 8;
  localparam int WIN = 5;
  localparam int CPS = 3;
  localparam int SW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [SW-1:0] cmd_sector = '0;
  logic          stat_rd = 1'b0;
  logic          cmd_ready;
  logic [7:0]    status;
  logic [N-1:0]  sector_map;
  logic          erase_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sec_erase_ctl #(.N_SECT(N), .WINDOW_CYCLES(WIN), .CYCLES_PER_SECTOR(CPS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sector(cmd_sector), .stat_rd(stat_rd),
    .status(status), .sector_map(sector_map), .erase_busy(erase_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input int sec);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_sector = SW'(sec);
    @(negedge clk);
    cmd_valid  = 1'b0;
    cmd_op     = 3'd0;
  endtask

  task automatic check_idle(input string req);
    chk(!erase_busy, req, "busy after finish", erase_busy, 0);
    chk(status[7] && !status[3], req, "status bits 7/3 idle", status, 8'h80);
    chk(sector_map == '0, req, "map cleared", sector_map, 0);
    chk(cmd_ready, "R1", "ready high", cmd_ready, 1);
  endtask

  // Window cycles with bit3=0, then erase cycles with bit3=1, then idle.
  task automatic expect_run(input int win, input int ers, input logic [N-1:0] m,
                            input string req);
    for (int i = 0; i < win; i++) begin
      chk(erase_busy && !status[3] && !status[7], req, "window status", status, 0);
      chk(sector_map == m, req, "window map", sector_map, m);
      step();
    end
    for (int i = 0; i < ers; i++) begin
      chk(erase_busy && status[3] && !status[7], req, "erase status bit3", status[3], 1);
      chk(sector_map == m, req, "erase map", sector_map, m);
      chk((status & 8'h37) == 8'h00, "R8", "unused status bits", status & 8'h37, 0);
      step();
    end
    check_idle("R4");
  endtask

  task automatic test_single();
    for (int s = 0; s < N; s++) begin
      issue(3'd1, s);
      expect_run(WIN, CPS, N'(1) << s, "R2");
    end
  endtask

  task automatic test_masks();
    for (int mask = 1; mask < (1 << N); mask++) begin
      logic [N-1:0] acc;
      bit first;
      int g;
      acc = '0;
      first = 1'b1;
      for (int b = 0; b < N; b++) begin
        if (mask[b]) begin
          if (first) begin
            issue(3'd1, b);
            first = 1'b0;
          end else begin
            g = (mask + b) % WIN;
            for (int k = 0; k < g; k++) begin
              chk(!status[3] && sector_map == acc, "R3", "open window map", sector_map, acc);
              step();
            end
            issue(3'd2, b);
          end
          acc[b] = 1'b1;
        end
      end
      expect_run(WIN, $countones(acc) * CPS, acc, "R3");
    end
    issue(3'd1, 3);
    issue(3'd2, 3);
    expect_run(WIN, CPS, 8'h08, "R3");
  endtask

  task automatic test_ignore_in_erase();
    logic [2:0] ops [4];
    ops[0] = 3'd2; ops[1] = 3'd1; ops[2] = 3'd3; ops[3] = 3'd5;
    issue(3'd1, 2);
    issue(3'd2, 5);
    for (int i = 0; i < WIN; i++) step();
    for (int j = 0; j < 4; j++) begin
      chk(status[3] && sector_map == 8'h24, "R5", "map during ignored cmd", sector_map, 8'h24);
      issue(ops[j], 7 - j);
    end
    for (int i = 0; i < 2 * CPS - 4; i++) begin
      chk(erase_busy && status[3] && sector_map == 8'h24, "R5", "erase length", erase_busy, 1);
      step();
    end
    check_idle("R5");
  endtask

  task automatic test_suspend();
    issue(3'd1, 1);
    issue(3'd2, 4);
    for (int i = 0; i < WIN; i++) step();
    step();
    step();
    issue(3'd4, 0);
    for (int i = 0; i < 6; i++) begin
      chk(erase_busy && status[3] && !status[7], "R7", "held status", status, 8'h08);
      chk(sector_map == 8'h12, "R7", "held map", sector_map, 8'h12);
      if (i == 2)      issue(3'd2, 6);
      else if (i == 4) issue(3'd4, 0);
      else             step();
    end
    issue(3'd5, 0);
    for (int i = 0; i < 2 * CPS - 2; i++) begin
      chk(erase_busy && status[3], "R7", "resumed erase remaining", erase_busy, 1);
      step();
    end
    check_idle("R7");
    // suspend/resume during the window do not delay or stop it
    issue(3'd1, 0);
    step();
    issue(3'd4, 0);
    issue(3'd5, 0);
    expect_run(WIN - 3, CPS, 8'h01, "R7");
  endtask

  task automatic test_idle_ignore();
    logic [2:0] ops [4];
    ops[0] = 3'd0; ops[1] = 3'd2; ops[2] = 3'd4; ops[3] = 3'd5;
    for (int j = 0; j < 4; j++) begin
      issue(ops[j], 3);
      check_idle("R9");
      step();
      check_idle("R9");
    end
  endtask

  task automatic test_chip_toggle();
    logic prev;
    issue(3'd3, 0);
    prev = status[6];
    stat_rd = 1'b1;
    for (int i = 0; i < N * CPS; i++) begin
      chk(erase_busy && status[3] && sector_map == 8'hFF, "R6", "chip erase state",
          sector_map, 8'hFF);
      if (i > 0) chk(status[6] != prev, "R8", "toggle bit flips", status[6], !prev);
      prev = status[6];
      step();
    end
    chk(status[6] != prev, "R8", "last busy read flips", status[6], !prev);
    prev = status[6];
    for (int i = 0; i < 3; i++) begin
      step();
      chk(status[6] == prev, "R8", "toggle idle hold", status[6], prev);
    end
    stat_rd = 1'b0;
    check_idle("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h80, "R1", "reset status", status, 8'h80);
    chk(sector_map == '0 && !erase_busy, "R1", "reset map/busy", sector_map, 0);
    chk(cmd_ready, "R1", "reset ready", cmd_ready, 1);
    test_single();
    test_masks();
    test_ignore_in_erase();
    test_suspend();
    test_idle_ignore();
    test_chip_toggle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule